// File: doc/BRIEF.md
# Triggered One-Shot Multichannel Servo Pulse Timer

This block generates the control pulses for a bank of hobby servos from a single shared timebase. A frame counter runs continuously and wraps at a programmable length; at the default design point this is a 20 ms, 50 Hz frame. On each wrap it raises a single-cycle trigger. A second counter, the shot counter, stays idle until that trigger arrives. It then counts exactly once from its start value to its end value and disables itself. After that it sits in the same state it had before the trigger and waits for the next one.

All channels share the shot counter and its limit. Each channel has its own compare value, which sets the width of its pulse: roughly 1 to 2 ms out of each frame for a servo. The shot counter runs only for a small part of the frame. Its full range is therefore spent on the pulse itself, which gives fine resolution. At a 168 MHz clock, 1 ms is 168,000 counts, and the default counter width of 20 bits holds that.

A prescaler slows the shot counter. The shot counter can count up or down. A per-channel polarity bit sets the output's idle level. The limit, prescaler, direction and compare values are captured only when a shot starts, so changing them during a pulse cannot distort that pulse.

Top module: `servo_oneshot_pulser`

## Requirements
- R1: The frame counter raises its trigger once every `frame_len`+1 clock cycles. When the shot is shorter than the frame, consecutive rises of `busy` are exactly `frame_len`+1 cycles apart.
- R2: Out of reset, and whenever `busy` is low, every `pulse_out[i]` sits at its inactive level, which equals `polarity[i]`.
- R3: A trigger that finds the shot counter idle starts a shot, and `busy` rises in the following cycle.
  - The shot lasts (`limit`+1)·(`prescale`+1) cycles.
  - The prescaler restarts from zero at each start.
  - `busy` then falls by itself.
- R4: A trigger that arrives while `busy` is high is ignored. This includes a trigger in the shot's last cycle. The running shot keeps its length, and the next shot waits for a later trigger.
- R5: When counting up (`count_down`=0), channel i is active for the first min(c, `limit`+1)·(`prescale`+1) cycles of the shot. Here c is bits [i·CNT_W +: CNT_W] of `compare`.
- R6: When counting down (`count_down`=1), channel i is active for the last min(c, `limit`+1)·(`prescale`+1) cycles of the shot.
- R7: A compare value of 0 keeps its channel inactive for the whole shot.
- R8: `polarity[i]`=1 inverts channel i. It is then low while active and high while inactive.
- R9: `limit`, `prescale`, `count_down` and `compare` are sampled only in the cycle a shot starts. Changing them during a shot does not affect that shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_len | input | FRAME_W | Frame length minus one, in clock cycles |
| prescale | input | PRE_W | Shot counter advances every `prescale`+1 cycles |
| limit | input | CNT_W | Shot end value, shared by all channels |
| count_down | input | 1 | 0 = shot counts 0 up to limit, 1 = limit down to 0 |
| compare | input | N_CH·CNT_W | Per-channel compare values, channel i at [i·CNT_W +: CNT_W] |
| polarity | input | N_CH | Per-channel inversion, 1 = active low |
| pulse_out | output | N_CH | Servo pulse lines |
| busy | output | 1 | High while a shot is running |

## Verification
The delicate case is a frame trigger that lands in the same cycle as the shot counter's final tick. The shot ends at that edge, but the trigger still finds the counter busy, so it must be dropped rather than used to restart. The bench provokes this by setting the frame to exactly the shot length. It then expects the gap between starts to be two frames; a shorter frame that lands mid-shot must also skip a start. A behavioural model tracks the elapsed cycles of each shot and compares `busy` and every channel against it on every clock.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  // Value the shot counter holds at rest and loads when a shot begins.
  function automatic logic [31:0] home_count(input logic [31:0] lim, input cnt_dir_e dir);
    return (dir == CNT_DOWN) ? lim : 32'd0;
  endfunction

  // One step of the shot counter in the selected direction.
  function automatic logic [31:0] step_count(input logic [31:0] c, input cnt_dir_e dir);
    return (dir == CNT_DOWN) ? c - 32'd1 : c + 32'd1;
  endfunction

  // True when the counter holds the last value of the shot.
  function automatic logic at_end(input logic [31:0] c, input logic [31:0] lim,
                                  input cnt_dir_e dir);
    return (dir == CNT_DOWN) ? (c == 32'd0) : (c == lim);
  endfunction

  // Channel is active while the count lies below its compare value.
  function automatic logic in_pulse(input logic [31:0] c, input logic [31:0] cmp);
    return c < cmp;
  endfunction

endpackage

// File: rtl/spp_frame_timer.sv
module spp_frame_timer #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_len,
  output logic               trig
);

  logic [FRAME_W-1:0] fcnt;

  assign trig = (fcnt >= frame_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= '0;
    end else if (trig) begin
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + FRAME_W'(1);
    end
  end

endmodule

// File: rtl/spp_oneshot.sv
module spp_oneshot #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] limit_in,
  input  logic [PRE_W-1:0] prescale_in,
  input  logic             count_down_in,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_lim,
  output logic             start,
  output logic             done
);
  import spp_pkg::*;

  cnt_dir_e         act_dir;
  cnt_dir_e         dir_in;
  logic [PRE_W-1:0] act_pre;
  logic [PRE_W-1:0] pre_cnt;
  logic             tick;

  assign dir_in = cnt_dir_e'(count_down_in);
  assign start  = trig && !run;
  assign tick   = run && (pre_cnt == act_pre);
  assign done   = tick && at_end(32'(cnt), 32'(act_lim), act_dir);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      act_lim <= '0;
      act_pre <= '0;
      act_dir <= CNT_UP;
      pre_cnt <= '0;
    end else if (start) begin
      run     <= 1'b1;
      act_lim <= limit_in;
      act_pre <= prescale_in;
      act_dir <= dir_in;
      pre_cnt <= '0;
      cnt     <= CNT_W'(home_count(32'(limit_in), dir_in));
    end else if (tick) begin
      pre_cnt <= '0;
      if (done) begin
        run <= 1'b0;
        cnt <= CNT_W'(home_count(32'(act_lim), act_dir));
      end else begin
        cnt <= CNT_W'(step_count(32'(cnt), act_dir));
      end
    end else if (run) begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/spp_channel.sv
module spp_channel #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             pol,
  output logic             pulse
);
  import spp_pkg::*;

  logic [CNT_W-1:0] act_cmp;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cmp <= '0;
    end else if (start) begin
      act_cmp <= cmp_in;
    end
  end

  assign active = run && in_pulse(32'(cnt), 32'(act_cmp));
  assign pulse  = active ^ pol;

endmodule

// File: rtl/servo_oneshot_pulser.sv
module servo_oneshot_pulser #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned PRE_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAME_W-1:0]    frame_len,
  input  logic [PRE_W-1:0]      prescale,
  input  logic [CNT_W-1:0]      limit,
  input  logic                  count_down,
  input  logic [N_CH*CNT_W-1:0] compare,
  input  logic [N_CH-1:0]       polarity,
  output logic [N_CH-1:0]       pulse_out,
  output logic                  busy
);

  localparam int unsigned CMP_BUS_W = N_CH * CNT_W;

  logic             frame_trig;
  logic             shot_start;
  logic             shot_done;
  logic [CNT_W-1:0] slave_cnt;
  logic [CNT_W-1:0] act_limit;

  spp_frame_timer #(.FRAME_W(FRAME_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_len (frame_len),
    .trig      (frame_trig)
  );

  spp_oneshot #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_shot (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig          (frame_trig),
    .limit_in      (limit),
    .prescale_in   (prescale),
    .count_down_in (count_down),
    .run           (busy),
    .cnt           (slave_cnt),
    .act_lim       (act_limit),
    .start         (shot_start),
    .done          (shot_done)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int unsigned LO = g * CNT_W;
    if (LO + CNT_W <= CMP_BUS_W) begin : g_ok
      spp_channel #(.CNT_W(CNT_W)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (shot_start),
        .cmp_in (compare[LO +: CNT_W]),
        .run    (busy),
        .cnt    (slave_cnt),
        .pol    (polarity[g]),
        .pulse  (pulse_out[g])
      );
    end
  end

endmodule

// File: rtl/spp_pulser_chk.sv
module spp_pulser_chk #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned FRAME_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_trig,
  input logic               shot_start,
  input logic               shot_done,
  input logic               busy,
  input logic [N_CH-1:0]    pulse_out,
  input logic [N_CH-1:0]    polarity,
  input logic [FRAME_W-1:0] frame_len,
  input logic [CNT_W-1:0]   act_limit
);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trig |=> (frame_trig == (frame_len == '0)));

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pulse_out == polarity));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shot_start |=> busy);

  // R3
  self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shot_done |=> !busy);

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_trig));

  // R4
  trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_trig && busy && !shot_done) |=> busy);

  // R4
  last_cycle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_trig && shot_done) |=> !busy);

  // R9
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_limit));

endmodule

bind servo_oneshot_pulser spp_pulser_chk #(
  .N_CH(N_CH), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_trig (frame_trig),
  .shot_start (shot_start),
  .shot_done  (shot_done),
  .busy       (busy),
  .pulse_out  (pulse_out),
  .polarity   (polarity),
  .frame_len  (frame_len),
  .act_limit  (act_limit)
);

// File: tb/servo_oneshot_pulser_bench.sv
`timescale 1ns/1ps
module servo_oneshot_pulser_bench;
  localparam int N_CH = 4, CNT_W = 20, FRAME_W = 24, PRE_W = 8;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [FRAME_W-1:0]    frame_len;
  logic [PRE_W-1:0]      prescale;
  logic [CNT_W-1:0]      limit;
  logic                  count_down;
  logic [N_CH*CNT_W-1:0] compare;
  logic [N_CH-1:0]       polarity;
  logic [N_CH-1:0]       pulse_out;
  logic                  busy;

  always #2 clk = ~clk;

  servo_oneshot_pulser #(.N_CH(N_CH), .CNT_W(CNT_W), .FRAME_W(FRAME_W), .PRE_W(PRE_W))
    u_servo_oneshot_pulser (
      .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .prescale(prescale),
      .limit(limit), .count_down(count_down), .compare(compare),
      .polarity(polarity), .pulse_out(pulse_out), .busy(busy));

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  bit    chk_en = 0;
  bit    finished = 0;
  string cur_req = "R2";

  // Behavioural reference: frame position, elapsed cycles of the current shot.
  int m_f = 0, m_e = 0, m_len = 0, m_lim = 0, m_pre = 0;
  bit m_run = 0, m_down = 0;
  int m_cmp[N_CH];

  always @(posedge clk) begin
    bit tr, was;
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_f = 0; m_e = 0; m_run = 0; m_len = 0; m_lim = 0; m_pre = 0; m_down = 0;
      foreach (m_cmp[i]) m_cmp[i] = 0;
    end else begin
      tr  = (m_f >= int'(frame_len));
      m_f = tr ? 0 : m_f + 1;
      was = m_run;
      if (was) begin
        m_e++;
        if (m_e >= m_len) m_run = 0;
      end
      if (tr && !was) begin
        m_run  = 1; m_e = 0;
        m_lim  = int'(limit); m_pre = int'(prescale); m_down = count_down;
        m_len  = (m_lim + 1) * (m_pre + 1);
        for (int i = 0; i < N_CH; i++) m_cmp[i] = int'(compare[i*CNT_W +: CNT_W]);
      end
    end
  end

  function automatic bit exp_out(int ch);
    int w, c;
    bit act;
    c = (m_cmp[ch] < m_lim + 1) ? m_cmp[ch] : m_lim + 1;
    w = c * (m_pre + 1);
    if (!m_run)      act = 0;
    else if (!m_down) act = (m_e < w);
    else             act = (m_e >= m_len - w);
    return act ^ polarity[ch];
  endfunction

  always @(negedge clk) begin
    if (chk_en && !finished) begin
      total++;
      if (busy !== m_run) begin
        bad++;
        $display("FAIL %s busy at cycle %0d actual=%0b expected=%0b", cur_req, cyc, busy, m_run);
      end
      for (int i = 0; i < N_CH; i++) begin
        total++;
        if (pulse_out[i] !== exp_out(i)) begin
          bad++;
          $display("FAIL %s pulse_out[%0d] at cycle %0d actual=%0b expected=%0b",
                   cur_req, i, cyc, pulse_out[i], exp_out(i));
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL R3 watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_step();
    @(negedge clk); #1;
  endtask

  task automatic set_cmp(int a, int b, int c, int d);
    compare[0*CNT_W +: CNT_W] = CNT_W'(a);
    compare[1*CNT_W +: CNT_W] = CNT_W'(b);
    compare[2*CNT_W +: CNT_W] = CNT_W'(c);
    compare[3*CNT_W +: CNT_W] = CNT_W'(d);
  endtask

  // Returns at the first negedge where a fresh shot is running.
  task automatic wait_rise();
    @(negedge clk);
    while (busy) @(negedge clk);
    while (!busy) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    wait_rise();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic active_len(int ch, output int n);
    wait_rise();
    n = 0;
    while (busy) begin
      if (pulse_out[ch] ^ polarity[ch]) n++;
      @(negedge clk);
    end
  endtask

  task automatic rise_gap(output int gap);
    int t0;
    wait_rise();
    t0 = cyc;
    @(negedge clk);
    while (busy) @(negedge clk);
    while (!busy) @(negedge clk);
    gap = cyc - t0;
  endtask

  initial begin
    int n, t0;
    frame_len = FRAME_W'(399); prescale = '0; limit = CNT_W'(49); count_down = 1'b0;
    polarity = '0; compare = '0;
    set_cmp(10, 20, 50, 70);
    repeat (3) @(negedge clk);
    chk_en = 1;
    // R2: reset state
    check("R2", "busy in reset", int'(busy), 0);
    check("R2", "pulse_out in reset", int'(pulse_out), 0);
    drive_step(); rst_n = 1'b1;

    // R1: frame spacing
    cur_req = "R1";
    rise_gap(n);  check("R1", "start spacing", n, 400);

    // R5: up-count widths, with clipping at limit+1
    cur_req = "R5";
    active_len(1, n); check("R5", "ch1 width", n, 20);
    active_len(3, n); check("R5", "ch3 clipped width", n, 50);
    active_len(0, n); check("R5", "ch0 width", n, 10);

    // R3: prescaler stretches the shot
    cur_req = "R3";
    drive_step(); prescale = PRE_W'(2);
    busy_len(n);      check("R3", "shot length pre=2", n, 150);
    active_len(0, n); check("R3", "ch0 width pre=2", n, 30);

    // R6: down counting places pulse at shot end
    cur_req = "R6";
    drive_step(); count_down = 1'b1; prescale = PRE_W'(1);
    busy_len(n);      check("R6", "shot length down", n, 100);
    active_len(1, n); check("R6", "ch1 width down", n, 40);

    // R8: inverted channels
    cur_req = "R8";
    drive_step(); polarity = 4'b0101; count_down = 1'b0;
    active_len(0, n); check("R8", "ch0 active-low width", n, 20);
    @(negedge clk);
    check("R8", "ch0 idle level high", int'(pulse_out[0]), 1);
    check("R8", "ch1 idle level low", int'(pulse_out[1]), 0);

    // R7: zero compare never asserts
    cur_req = "R7";
    drive_step(); set_cmp(5, 15, 0, 30); polarity = '0;
    active_len(2, n); check("R7", "ch2 zero compare width", n, 0);

    // R9: changes mid-shot do not touch the running shot
    cur_req = "R9";
    wait_rise(); t0 = cyc;
    #1; limit = CNT_W'(9); prescale = '0; count_down = 1'b1; set_cmp(3, 3, 3, 3);
    while (busy) @(negedge clk);
    check("R9", "running shot length kept", cyc - t0, 100);
    busy_len(n);      check("R9", "next shot uses new limit", n, 10);
    active_len(0, n); check("R9", "next shot uses new compare", n, 3);

    // R4: trigger in last shot cycle, then mid-shot
    cur_req = "R4";
    drive_step(); limit = CNT_W'(49); prescale = PRE_W'(1); count_down = 1'b0;
    frame_len = FRAME_W'(99);
    busy_len(n);      check("R4", "shot length", n, 100);
    rise_gap(n);      check("R4", "trigger on final cycle skipped", n, 200);
    drive_step(); frame_len = FRAME_W'(59);
    rise_gap(n);      check("R4", "trigger mid-shot skipped", n, 120);
    busy_len(n);      check("R4", "shot not restarted", n, 100);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule